// File: doc/BRIEF.md
# Shared-Coefficient 32-Tap FIR Filter

This block is a 32-tap feed-forward FIR filter for signed samples. Its cost saving comes from taps that carry the same coefficient value. Each tap is assigned to a coefficient group by a parameter table. Every cycle, the delayed samples in a group are added together, and the group total is multiplied once by that group's coefficient. The block therefore has one multiplier per distinct coefficient, not one per tap. Each multiplier is a radix-4 recoded two's-complement array, and its group products are added into a single filtered result.

A sample enters on `in_data` when `in_valid` is high, and only accepted samples move the delay line. Each accepted sample produces exactly one output word on `out_data`, marked by a one-cycle `out_valid`, after a fixed pipeline delay. The pipeline has three register stages after the delay line: the group pre-add, the product and the final sum. The output word is held between results.

Top module: `fir_share_top`

## Requirements
- R1: While `rst` is high on a clock edge, the delay line is cleared to zero and `out_valid` and `out_data` are cleared to zero. Both stay zero until the first result appears.
- R2: A sample accepted at clock edge E produces `out_valid` high after edge E+3, for one cycle. There is exactly one result per accepted sample, and results come out in order.
- R3: Each result equals the sum over k = 0..31 of h[k]·x[n-k], bit for bit, for signed 8-bit samples. Here x[n] is the newest accepted sample, and h[k] is the coefficient of the group that tap k belongs to.
- R4: The default grouping is as follows. Group 0 holds taps {0,2,6,31} with coefficient -128. Group 1 holds taps {1,5,16} with 127. Group 2 holds taps {19,20} with -3. Group 3 holds taps {3,10,15,23,28} with 45. Group 4 holds taps {4,11,17,24,29} with -77. Group 5 holds taps {7,12,18,25,30} with 12. Group 6 holds taps {8,13,21,26} with 99. Group 7 holds taps {9,14,22,27} with -50. Taps in one group are pre-added before a single multiply.
- R5: An impulse of amplitude A, followed by zero samples, produces A·h[0], A·h[1], ..., A·h[31], and then only zeros.
- R6: Cycles with `in_valid` low do not move the delay line, so idle gaps between samples do not change any result.
- R7: While `out_valid` is low, `out_data` keeps its previous value.
- R8: The 21-bit output does not overflow, even when every tap holds the most negative or most positive sample that matches its coefficient sign.
- R9: The multiply is correct for the most negative coefficient (-128) and for the most negative sample (-128).
- R10: After a reset, the first results are computed with all older history taken as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample accepted on this edge |
| in_data | input | 8 | Signed input sample |
| out_valid | output | 1 | One-cycle marker of a new result |
| out_data | output | 21 | Signed filtered result, held between results |

## Verification
The checker assumes that `rst` is held for at least one edge before traffic starts. It also assumes that samples are ordinary signed 8-bit values, which is what makes its magnitude bound on the output hold. The latency check counts edges since reset, so it also assumes that `in_valid` is low during reset. The stimulus respects all of this. It holds `in_valid` low through every reset and draws samples across the full signed range, including -128. It adds random idle gaps, plus directed impulses, constant runs and a sign-matched worst case for output magnitude.

// File: rtl/fir_share_pkg.sv
package fir_share_pkg;

  // extra bits needed to add n signed terms without overflow
  function automatic int extra_bits(input int n);
    int b;
    b = 0;
    while ((1 << b) < n) b++;
    return b;
  endfunction

  // radix-4 recoded digit actions
  typedef enum logic [2:0] {
    DIG_ZERO,
    DIG_POS1,
    DIG_POS2,
    DIG_NEG1,
    DIG_NEG2
  } r4_digit_e;

endpackage

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
  parameter int TAPS = 32,
  parameter int DW   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic [DW-1:0]        din,
  output logic [TAPS*DW-1:0]   tap_bus
);
  // tap k occupies bits [k*DW +: DW]; tap 0 holds the newest sample
  genvar k;
  generate
    for (k = 0; k < TAPS; k++) begin : g_tap
      always_ff @(posedge clk) begin
        if (rst) begin
          tap_bus[k*DW +: DW] <= '0;
        end else if (shift_en) begin
          if (k == 0) tap_bus[k*DW +: DW] <= din;
          else        tap_bus[k*DW +: DW] <= tap_bus[(k-1)*DW +: DW];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/fir_group_sum.sv
module fir_group_sum #(
  parameter int TAPS = 32,
  parameter int DW   = 8,
  parameter int SW   = 10,
  parameter int GID  = 0,
  parameter int GRP_OF [TAPS] = '{default: 0}
) (
  input  logic [TAPS*DW-1:0]   tap_bus,
  output logic signed [SW-1:0] sum
);
  always_comb begin
    logic signed [DW-1:0] t;
    sum = '0;
    for (int k = 0; k < TAPS; k++) begin
      t = tap_bus[k*DW +: DW];
      if (GRP_OF[k] == GID) sum = sum + SW'(t);
    end
  end
endmodule

// File: rtl/booth_r4_mult.sv
module booth_r4_mult
  import fir_share_pkg::*;
#(
  parameter int AW = 10,
  parameter int BW = 8
) (
  input  logic signed [AW-1:0]    a,
  input  logic signed [BW-1:0]    b,
  output logic signed [AW+BW-1:0] p
);
  localparam int ND = (BW + 1) / 2;
  localparam int EB = 2 * ND;
  localparam int PW = AW + BW;

  logic signed [EB-1:0] b_ext;
  logic [EB:0]          b_win;
  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] pp [ND];

  assign b_ext = EB'(b);
  assign b_win = {b_ext, 1'b0};
  assign a_ext = PW'(a);

  genvar d;
  generate
    for (d = 0; d < ND; d++) begin : g_digit
      r4_digit_e            dig;
      logic signed [PW-1:0] mag;
      always_comb begin
        case (b_win[2*d+2 -: 3])
          3'b001, 3'b010: dig = DIG_POS1;
          3'b011:         dig = DIG_POS2;
          3'b100:         dig = DIG_NEG2;
          3'b101, 3'b110: dig = DIG_NEG1;
          default:        dig = DIG_ZERO;
        endcase
        case (dig)
          DIG_POS1: mag = a_ext;
          DIG_POS2: mag = a_ext <<< 1;
          DIG_NEG1: mag = -a_ext;
          DIG_NEG2: mag = -(a_ext <<< 1);
          default:  mag = '0;
        endcase
        pp[d] = mag <<< (2 * d);
      end
    end
  endgenerate

  always_comb begin
    p = '0;
    for (int i = 0; i < ND; i++) p = p + pp[i];
  end
endmodule

// File: rtl/fir_share_top.sv
module fir_share_top
  import fir_share_pkg::*;
#(
  parameter int TAPS = 32,
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int NGRP = 8,
  parameter int OW   = DW + CW + $clog2(TAPS),
  parameter int GRP_OF [TAPS] = '{0, 1, 0, 3, 4, 1, 0, 5, 6, 7, 3, 4, 5, 6, 7, 3,
                                  1, 4, 5, 2, 2, 6, 7, 3, 4, 5, 6, 7, 3, 4, 5, 0},
  parameter int GRP_COEF [NGRP] = '{-128, 127, -3, 45, -77, 12, 99, -50}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  function automatic int members(input int g);
    int n;
    n = 0;
    for (int k = 0; k < TAPS; k++) if (GRP_OF[k] == g) n++;
    return n;
  endfunction

  logic [TAPS*DW-1:0]   tap_bus;
  logic [2:0]           vpipe;
  logic signed [OW-1:0] prod_ext [NGRP];
  logic signed [OW-1:0] total;

  fir_delay_line #(.TAPS(TAPS), .DW(DW)) u_dl (
    .clk      (clk),
    .rst      (rst),
    .shift_en (in_valid),
    .din      (in_data),
    .tap_bus  (tap_bus)
  );

  // vpipe[0]: delay line updated, [1]: group sums, [2]: products
  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[1:0], in_valid};
  end

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_grp
      localparam int N  = members(g);
      localparam int SW = DW + extra_bits(N);
      localparam int PW = SW + CW;

      logic signed [SW-1:0] sum_c, sum_q;
      logic signed [PW-1:0] prod_c, prod_q;
      logic signed [CW-1:0] coef;

      assign coef = CW'(GRP_COEF[g]);

      fir_group_sum #(
        .TAPS(TAPS), .DW(DW), .SW(SW), .GID(g), .GRP_OF(GRP_OF)
      ) u_sum (
        .tap_bus (tap_bus),
        .sum     (sum_c)
      );

      booth_r4_mult #(.AW(SW), .BW(CW)) u_mul (
        .a (sum_q),
        .b (coef),
        .p (prod_c)
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          sum_q  <= '0;
          prod_q <= '0;
        end else begin
          sum_q  <= sum_c;
          prod_q <= prod_c;
        end
      end

      assign prod_ext[g] = OW'(prod_q);
    end
  endgenerate

  always_comb begin
    total = '0;
    for (int i = 0; i < NGRP; i++) total = total + prod_ext[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= vpipe[2];
      if (vpipe[2]) out_data <= total;
    end
  end
endmodule

// File: rtl/fir_share_chk.sv
module fir_share_chk #(
  parameter int TAPS = 32,
  parameter int DW   = 8,
  parameter int NGRP = 8,
  parameter int OW   = 21,
  parameter int GRP_OF [TAPS] = '{default: 0},
  parameter int GRP_COEF [NGRP] = '{default: 0}
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_data
);
  function automatic longint mag_bound();
    longint s;
    longint c;
    s = 0;
    for (int k = 0; k < TAPS; k++) begin
      c = longint'(GRP_COEF[GRP_OF[k]]);
      s = s + ((c < 0) ? -c : c) * (longint'(1) << (DW - 1));
    end
    return s;
  endfunction

  localparam longint BND = mag_bound();

  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  // R1: the edge after reset leaves the output cleared
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_data == '0));

  // R2: a result appears exactly when a sample was accepted three edges earlier
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

  // R7: the output word holds while no result is flagged
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd1 && !out_valid) |-> (out_data == $past(out_data)));

  // R8: every result stays within the worst-case magnitude
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (longint'(out_data) <= BND && longint'(out_data) >= -BND));
endmodule

bind fir_share_top fir_share_chk #(
  .TAPS(TAPS), .DW(DW), .NGRP(NGRP), .OW(OW),
  .GRP_OF(GRP_OF), .GRP_COEF(GRP_COEF)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/sim_fir_share_top.sv
module sim_fir_share_top;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic signed [7:0] in_data = '0;
  logic              out_valid;
  logic signed [20:0] out_data;

  always #2 clk = ~clk;

  fir_share_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  // R4 grouping and coefficients
  int grp_map [32] = '{0, 1, 0, 3, 4, 1, 0, 5, 6, 7, 3, 4, 5, 6, 7, 3,
                       1, 4, 5, 2, 2, 6, 7, 3, 4, 5, 6, 7, 3, 4, 5, 0};
  int grp_cf  [8]  = '{-128, 127, -3, 45, -77, 12, 99, -50};

  int hist [32];
  int exp_q [$];
  int cyc_q [$];
  string tag_q [$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic monitor_on = 1'b0;
  logic signed [20:0] last_data = '0;
  string cur_tag = "R3";

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int h(input int k);
    return grp_cf[grp_map[k]];
  endfunction

  function automatic int model_out();
    int s;
    s = 0;
    for (int k = 0; k < 32; k++) s += hist[k] * h(k);
    return s;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int x);
    @(posedge clk);
    #1;
    in_valid = v;
    in_data  = 8'(x);
    if (v) begin
      for (int k = 31; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      exp_q.push_back(model_out());
      cyc_q.push_back(cyc + 4);
      tag_q.push_back(cur_tag);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 0);
  endtask

  task automatic do_reset();
    monitor_on = 1'b0;
    @(posedge clk);
    #1;
    rst = 1'b1;
    in_valid = 1'b0;
    for (int k = 0; k < 32; k++) hist[k] = 0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_data), 0);
    last_data = out_data;
    monitor_on = 1'b1;
  endtask

  always @(negedge clk) begin
    if (monitor_on) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check("R2", 1, 0);
        end else begin
          check("R2", cyc, cyc_q.pop_front());
          check(tag_q.pop_front(), int'(out_data), exp_q.pop_front());
        end
      end else begin
        check("R7", int'(out_data), int'(last_data));
      end
      last_data = out_data;
    end
  end

  initial begin
    int gap;
    void'($urandom(32'd4242));
    for (int k = 0; k < 32; k++) hist[k] = 0;
    do_reset();

    // R5 / R10: impulse into a cleared history
    cur_tag = "R5";
    drive(1'b1, 100);
    for (int i = 0; i < 34; i++) drive(1'b1, 0);
    // R9: most negative sample against the -128 coefficient
    cur_tag = "R9";
    drive(1'b1, -128);
    for (int i = 0; i < 33; i++) drive(1'b1, 0);
    // R4: constant runs fill every group equally
    cur_tag = "R4";
    for (int i = 0; i < 36; i++) drive(1'b1, 5);
    // R8: sign-matched worst case in both directions
    cur_tag = "R8";
    for (int j = 0; j < 32; j++) drive(1'b1, (h(31 - j) < 0) ? -128 : 127);
    for (int j = 0; j < 32; j++) drive(1'b1, (h(31 - j) < 0) ? 127 : -128);
    for (int i = 0; i < 34; i++) drive(1'b1, -128);
    idle(6);

    // R3 / R6: random samples with random gaps
    for (int i = 0; i < 600; i++) begin
      gap = ($urandom_range(3) == 0) ? int'($urandom_range(3)) + 1 : 0;
      idle(gap);
      cur_tag = (gap > 0) ? "R6" : "R3";
      drive(1'b1, int'($urandom_range(255)) - 128);
    end
    idle(8);

    // R10: reset mid-stream, history must restart from zero
    for (int i = 0; i < 10; i++) drive(1'b1, 90);
    idle(8);
    do_reset();
    cur_tag = "R10";
    drive(1'b1, 77);
    drive(1'b1, -20);
    idle(8);
    check("R2", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule